// File: doc/BRIEF.md
# Character LCD Nibble-Bus Sequencer

This block connects a host to a two-line, sixteen-column character display. The display is driven through a 4-bit data bus with a register-select line, a read/write line and an enable strobe. The host issues one request at a time over a valid/ready handshake. A request can send an instruction byte, send a character byte, place the cursor at a (line, column) position, or read back the busy flag and the current address. The block turns each request into the bus activity it needs. That includes splitting each byte into nibbles, the strobe timing, and the settling time before the next request is taken.

After reset the block first waits for the display's supply to settle. It then sends a fixed start-up programme of four instructions without any host involvement. Every delay is a clock-count parameter, so one build can run at any clock rate, and a bench can shrink the delays. Completion is tracked with timed waits, not by polling the busy flag. The host can still read that flag on request.

Top module: `lcdSeq`

## Requirements
- R1: While `rstN` is low and afterwards, `lcdE` stays low and `reqReady` stays low until the power-up wait of `POWER_CYC` cycles has run and the start-up programme is finished.
- R2: The start-up programme sends the instructions 0x28, 0x06, 0x0C and 0x01, in that order, each with RS=0 and RW=0.
- R3: Each byte crosses the bus as two enable pulses. Bits 7:4 go with the first pulse and bits 3:0 with the second. `lcdDataOut` is held constant while `lcdE` is high.
- R4: A request with `reqOp`=0 sends `reqByte` with RS=0 and RW=0.
- R5: A request with `reqOp`=1 sends `reqByte` with RS=1 and RW=0.
- R6: A request with `reqOp`=2 sends the instruction 0x80 | `reqCol` for line 0, or 0xC0 | `reqCol` for line 1 (`reqLine`=1). This uses RS=0 and RW=0.
- R7: A request with `reqOp`=3 makes two pulses with RS=0 and RW=1, and `lcdDataOe` low. The nibbles on `lcdDataIn`, first then second, are joined into `rspData`, which is shown with a single-cycle `rspValid` pulse.
- R8: RS and RW settle at least `SETUP_CYC` cycles before `lcdE` rises and do not change while it is high. `lcdE` stays high for at least `PULSE_CYC` cycles and stays low for at least `GAP_CYC` cycles between pulses.
- R9: After a written byte, the next pulse waits at least `CMD_CYC` cycles. After an instruction byte of 0x01, 0x02 or 0x03 (clear or home), it waits at least `LONG_CYC` cycles.
- R10: `reqReady` is low during any transfer or wait. A request presented while `reqReady` is low is kept and carried out later, never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqOp | input | 2 | 0 instruction, 1 character, 2 cursor, 3 status read |
| reqByte | input | 8 | Byte for instruction or character requests |
| reqLine | input | 1 | Cursor line |
| reqCol | input | 4 | Cursor column |
| rspValid | output | 1 | One-cycle strobe: rspData holds a status read |
| rspData | output | 8 | Busy flag (bit 7) and address (bits 6:0) |
| lcdRs | output | 1 | Register select to display |
| lcdRw | output | 1 | Read/write select (1 = read) |
| lcdE | output | 1 | Enable strobe |
| lcdDataOut | output | 4 | Nibble driven to display |
| lcdDataOe | output | 1 | Output enable for the nibble bus |
| lcdDataIn | input | 4 | Nibble returned by display |

## Verification
The assertions assume that the host keeps `reqOp`, `reqByte`, `reqLine` and `reqCol` steady while `reqValid` waits for `reqReady`. They also assume that `lcdDataIn` is steady during a read pulse. The stimulus changes inputs only on the falling clock edge. It holds each request until the rising edge where `reqReady` is high, and then withdraws it. The stimulus includes a request raised during the start-up programme. The display model returns a fixed status byte, chosen by which nibble is active, so the read value is known.

// File: rtl/lcdSeqPkg.sv
package lcdSeqPkg;
  typedef enum logic [1:0] {
    OP_INSTR  = 2'd0,
    OP_CHAR   = 2'd1,
    OP_CURSOR = 2'd2,
    OP_STATUS = 2'd3
  } reqOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadReq;
    logic       loadInit;
    logic [1:0] initSel;
    logic       lowNib;
    logic       eOn;
    logic       capture;
  } strobeT;
endpackage

// File: rtl/lcdSeqPath.sv
module lcdSeqPath
  import lcdSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      strb,
  input  logic [1:0]  reqOp,
  input  logic [7:0]  reqByte,
  input  logic        reqLine,
  input  logic [3:0]  reqCol,
  input  logic [3:0]  lcdDataIn,
  output logic        isRead,
  output logic        isLong,
  output logic        lcdRs,
  output logic        lcdRw,
  output logic        lcdE,
  output logic [3:0]  lcdDataOut,
  output logic        lcdDataOe,
  output logic [7:0]  rspData
);
  logic [7:0] byteQ;
  logic       rsQ, rwQ;
  logic [7:0] rdQ;

  function automatic logic [7:0] startByte(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h28;
      2'd1:    return 8'h06;
      2'd2:    return 8'h0C;
      default: return 8'h01;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteQ <= '0;
      rsQ   <= 1'b0;
      rwQ   <= 1'b0;
      rdQ   <= '0;
    end else begin
      if (strb.loadInit) begin
        byteQ <= startByte(strb.initSel);
        rsQ   <= 1'b0;
        rwQ   <= 1'b0;
      end else if (strb.loadReq) begin
        case (reqOpE'(reqOp))
          OP_INSTR:  begin byteQ <= reqByte; rsQ <= 1'b0; rwQ <= 1'b0; end
          OP_CHAR:   begin byteQ <= reqByte; rsQ <= 1'b1; rwQ <= 1'b0; end
          OP_CURSOR: begin
            byteQ <= {1'b1, reqLine, 2'b00, reqCol};
            rsQ   <= 1'b0;
            rwQ   <= 1'b0;
          end
          default:   begin byteQ <= 8'h00; rsQ <= 1'b0; rwQ <= 1'b1; end
        endcase
      end
      if (strb.capture) begin
        if (strb.lowNib) rdQ[3:0] <= lcdDataIn;
        else             rdQ[7:4] <= lcdDataIn;
      end
    end
  end

  assign isRead     = rwQ;
  assign isLong     = !rsQ && !rwQ && (byteQ[7:2] == 6'd0) && (byteQ[1:0] != 2'd0);
  assign lcdRs      = rsQ;
  assign lcdRw      = rwQ;
  assign lcdE       = strb.eOn;
  assign lcdDataOut = strb.lowNib ? byteQ[3:0] : byteQ[7:4];
  assign lcdDataOe  = !rwQ;
  assign rspData    = rdQ;

  a_r8_ctrl_lines_steady: assert property (@(posedge clk) disable iff (!rstN)
    lcdE && $past(lcdE) |-> $stable(lcdRs) && $stable(lcdRw));
  a_r3_nibble_held: assert property (@(posedge clk) disable iff (!rstN)
    lcdE && $past(lcdE) |-> $stable(lcdDataOut));
  a_r7_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    lcdRw |-> !lcdDataOe);
endmodule

// File: rtl/lcdSeqCtrl.sv
module lcdSeqCtrl
  import lcdSeqPkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 47,
  parameter int GAP_CYC   = 200,
  parameter int CMD_CYC   = 8000,
  parameter int LONG_CYC  = 328000,
  parameter int POWER_CYC = 3000000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   isRead,
  input  logic   isLong,
  output logic   reqReady,
  output logic   rspValid,
  output strobeT strb
);
  localparam int MAX_A = (POWER_CYC > LONG_CYC) ? POWER_CYC : LONG_CYC;
  localparam int CW    = $clog2(MAX_A + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_SETUP, S_PULSE, S_GAP, S_POST, S_RESP} stateE;

  stateE      state;
  logic [CW-1:0] cnt, waitLen;
  logic       nibQ, initDone;
  logic [1:0] initIdx;
  logic       pwrDone, postDone;

  assign pwrDone  = (state == S_PWR)  && (cnt == CW'(POWER_CYC - 1));
  assign postDone = (state == S_POST) && (cnt == waitLen - 1'b1);

  always_comb begin
    strb          = '0;
    strb.lowNib   = nibQ;
    strb.eOn      = (state == S_PULSE);
    strb.capture  = (state == S_PULSE) && (cnt == CW'(PULSE_CYC - 1));
    strb.loadReq  = (state == S_IDLE) && reqValid;
    strb.loadInit = pwrDone || (postDone && !initDone && initIdx != 2'd3);
    strb.initSel  = (state == S_PWR) ? 2'd0 : initIdx + 2'd1;
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_PWR;
      cnt      <= '0;
      waitLen  <= '0;
      nibQ     <= 1'b0;
      initDone <= 1'b0;
      initIdx  <= 2'd0;
    end else begin
      case (state)
        S_PWR: begin
          if (pwrDone) begin
            state <= S_SETUP; cnt <= '0; nibQ <= 1'b0; initIdx <= 2'd0;
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: if (reqValid) begin
          state <= S_SETUP; cnt <= '0; nibQ <= 1'b0;
        end
        S_SETUP: begin
          if (cnt == CW'(SETUP_CYC - 1)) begin state <= S_PULSE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_PULSE: begin
          if (cnt == CW'(PULSE_CYC - 1)) begin state <= S_GAP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            cnt <= '0;
            if (!nibQ) begin
              nibQ <= 1'b1; state <= S_SETUP;
            end else if (isRead) begin
              state <= S_RESP;
            end else begin
              state   <= S_POST;
              waitLen <= isLong ? CW'(LONG_CYC) : CW'(CMD_CYC);
            end
          end else cnt <= cnt + 1'b1;
        end
        S_POST: begin
          if (postDone) begin
            cnt <= '0;
            if (initDone) state <= S_IDLE;
            else if (initIdx == 2'd3) begin
              initDone <= 1'b1; state <= S_IDLE;
            end else begin
              initIdx <= initIdx + 2'd1; nibQ <= 1'b0; state <= S_SETUP;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_ready_excludes_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strb.eOn);
  a_r10_accept_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  a_r7_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r1_no_ready_before_init: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !reqReady);
endmodule

// File: rtl/lcdSeq.sv
module lcdSeq #(
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 47,
  parameter int GAP_CYC   = 200,
  parameter int CMD_CYC   = 8000,
  parameter int LONG_CYC  = 328000,
  parameter int POWER_CYC = 3000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] reqOp,
  input  logic [7:0] reqByte,
  input  logic       reqLine,
  input  logic [3:0] reqCol,
  output logic       rspValid,
  output logic [7:0] rspData,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdE,
  output logic [3:0] lcdDataOut,
  output logic       lcdDataOe,
  input  logic [3:0] lcdDataIn
);
  lcdSeqPkg::strobeT strb;
  logic isRead, isLong;

  lcdSeqCtrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC),
    .CMD_CYC(CMD_CYC), .LONG_CYC(LONG_CYC), .POWER_CYC(POWER_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isRead(isRead),
    .isLong(isLong), .reqReady(reqReady), .rspValid(rspValid), .strb(strb)
  );

  lcdSeqPath path (
    .clk(clk), .rstN(rstN), .strb(strb), .reqOp(reqOp), .reqByte(reqByte),
    .reqLine(reqLine), .reqCol(reqCol), .lcdDataIn(lcdDataIn),
    .isRead(isRead), .isLong(isLong), .lcdRs(lcdRs), .lcdRw(lcdRw),
    .lcdE(lcdE), .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe),
    .rspData(rspData)
  );
endmodule

// File: tb/lcdSeq_test.sv
`timescale 1ns/1ps
module lcdSeq_test;
  localparam int SETUP = 2, PULSE = 3, GAP = 4, CMDW = 20, LONGW = 60, POWER = 100;
  localparam logic [7:0] RDVAL = 8'hC7;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqLine = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [7:0] reqByte = 8'h00;
  logic [3:0] reqCol = 4'd0;
  logic reqReady, rspValid, lcdRs, lcdRw, lcdE, lcdDataOe;
  logic [7:0] rspData;
  logic [3:0] lcdDataOut, lcdDataIn;

  int total = 0, bad = 0, rspCnt = 0;
  bit finished = 1'b0;
  logic [9:0] expQ[$];
  int expTag[$];

  always #2.5 clk = ~clk;

  lcdSeq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .GAP_CYC(GAP),
           .CMD_CYC(CMDW), .LONG_CYC(LONGW), .POWER_CYC(POWER)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqByte(reqByte), .reqLine(reqLine), .reqCol(reqCol),
    .rspValid(rspValid), .rspData(rspData), .lcdRs(lcdRs), .lcdRw(lcdRw),
    .lcdE(lcdE), .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe),
    .lcdDataIn(lcdDataIn));

  task automatic check(input int tag, input bit ok, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // display model: status byte split by the active nibble
  logic monNib = 1'b0;
  assign lcdDataIn = monNib ? RDVAL[3:0] : RDVAL[7:4];

  // behavioural pin monitor, sampled on the falling edge
  logic prevE = 1'b0, prevRs = 1'b0, prevRw = 1'b0;
  logic [3:0] hiNib = 4'h0, curNib = 4'h0;
  int stabCnt = 0, sinceFall = 0, hiCnt = 0, waitNeed = 0, cyc = 0;
  bit seenRise = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] got;
      cyc++;
      if (lcdRs != prevRs || lcdRw != prevRw) stabCnt = 0; else stabCnt++;
      // R10: never ready while strobing
      if (lcdE && reqReady) check(10, 1'b0, 1, 0);
      if (lcdE && !prevE) begin
        if (!seenRise) begin
          check(1, cyc >= POWER, cyc, POWER);   // R1 power-up wait
          seenRise = 1'b1;
        end else if (monNib)
          check(8, sinceFall >= GAP, sinceFall, GAP);            // R8 gap
        else
          check(9, sinceFall >= GAP + waitNeed, sinceFall, GAP + waitNeed); // R9
        check(8, stabCnt >= SETUP, stabCnt, SETUP);               // R8 setup
        hiCnt = 0;
      end
      if (lcdE) begin
        hiCnt++;
        curNib = lcdDataOut;
        check(7, lcdDataOe == !lcdRw, lcdDataOe, !lcdRw);         // R7 bus release
      end
      if (!lcdE && prevE) begin
        check(8, hiCnt >= PULSE, hiCnt, PULSE);                   // R8 width
        sinceFall = 0;
        if (!monNib) begin
          hiNib = curNib;
          monNib = 1'b1;
        end else begin
          got = lcdRw ? 8'h00 : {hiNib, curNib};                  // R3 high then low
          monNib = 1'b0;
          if (expQ.size() == 0) check(3, 1'b0, {lcdRs, lcdRw, got}, 0);
          else begin
            logic [9:0] e;
            int t;
            e = expQ.pop_front();
            t = expTag.pop_front();
            check(t, {lcdRs, lcdRw, got} == e, {lcdRs, lcdRw, got}, e);
          end
          waitNeed = lcdRw ? 0 :
                     (!lcdRs && got != 8'h00 && got[7:2] == 6'd0) ? LONGW : CMDW;
        end
      end
      if (!lcdE) sinceFall++;
      if (rspValid) begin
        rspCnt++;
        check(7, rspData == RDVAL, rspData, RDVAL);               // R7 value
      end
      prevE = lcdE; prevRs = lcdRs; prevRw = lcdRw;
    end
  end

  task automatic expect1(input logic rs, input logic rw, input logic [7:0] b, input int tag);
    expQ.push_back({rs, rw, b});
    expTag.push_back(tag);
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] b, input logic ln, input logic [3:0] col);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqByte = b; reqLine = ln; reqCol = col;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, 1'b0, 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, lcdE == 1'b0, lcdE, 0);
    check(1, reqReady == 1'b0, reqReady, 0);
    rstN = 1'b1;
    // R2 start-up programme
    expect1(1'b0, 1'b0, 8'h28, 2);
    expect1(1'b0, 1'b0, 8'h06, 2);
    expect1(1'b0, 1'b0, 8'h0C, 2);
    expect1(1'b0, 1'b0, 8'h01, 2);
    // R10 request raised during start-up is held and carried out afterwards
    expect1(1'b0, 1'b0, 8'h0E, 10);
    send(2'd0, 8'h0E, 1'b0, 4'd0);
    // R5 character
    expect1(1'b1, 1'b0, 8'h48, 5);
    send(2'd1, 8'h48, 1'b0, 4'd0);
    // R6 cursor on both lines
    expect1(1'b0, 1'b0, 8'hC5, 6);
    send(2'd2, 8'h00, 1'b1, 4'd5);
    expect1(1'b0, 1'b0, 8'h8F, 6);
    send(2'd2, 8'hFF, 1'b0, 4'd15);
    // R7 status read
    expect1(1'b0, 1'b1, 8'h00, 7);
    send(2'd3, 8'h00, 1'b0, 4'd0);
    // R9 long wait after clear, then home
    expect1(1'b0, 1'b0, 8'h01, 9);
    send(2'd0, 8'h01, 1'b0, 4'd0);
    expect1(1'b1, 1'b0, 8'h41, 5);
    send(2'd1, 8'h41, 1'b0, 4'd0);
    expect1(1'b0, 1'b0, 8'h02, 9);
    send(2'd0, 8'h02, 1'b0, 4'd0);
    // R4 instruction with ordinary wait
    expect1(1'b0, 1'b0, 8'h18, 4);
    send(2'd0, 8'h18, 1'b0, 4'd0);
    expect1(1'b1, 1'b0, 8'h7E, 5);
    send(2'd1, 8'h7E, 1'b0, 4'd0);
    repeat (LONGW + 40) @(negedge clk);
    check(10, expQ.size() == 0, expQ.size(), 0);
    check(7, rspCnt == 1, rspCnt, 1);
    check(10, reqReady == 1'b1, reqReady, 1);
    finishRun();
  end
endmodule